// File: doc/BRIEF.md
# Address-Match Breakpoint Generator

This block watches a processor address bus and raises an active-high breakpoint signal when the bus carries a programmed address. Software programs the address through a small byte-wide register port. It also sets an enable bit and chooses one of two output behaviours.

In pulse mode, each accepted match produces a pulse of fixed length, counted in block clocks. In level mode, a match sets a sticky status flag, and the output follows that flag until software writes a 1 to its bit. Both modes record the match in the status flag, so software can still see that a break occurred after a short pulse has ended.

There are four register offsets. Offset 0 is control/status: bit 0 is enable, bit 1 selects pulse mode, bit 2 is the break status (write one to clear), and bits 7..3 read as zero. Offset 1 holds the low byte of the breakpoint address and offset 2 the high byte. Offset 3 reads as zero and ignores writes. Read data is registered, so it appears one clock after the address is presented. Writes take effect at the clock edge where the write strobe is high.

Top module: `bkpt_gen`

## Requirements
- R1: After synchronous reset, the breakpoint output is low and reads of offsets 0, 1 and 2 return 0x00. This means enable is off, pulse mode is off, status is clear and the breakpoint address is 0x0000.
- R2: A match requires all 16 bits of the bus to equal {offset 2 byte, offset 1 byte}. Agreement on only one byte, or byte-swapped agreement, never triggers.
- R3: While enable (offset 0 bit 0) is 0, a matching address leaves the output low and does not set the status bit.
- R4: The output and the status bit rise in the clock cycle after the one in which the matching address is sampled.
- R5: With pulse mode (offset 0 bit 1) at 1, a match drives the output high for exactly PULSE_LEN (default 8) consecutive cycles, then low.
- R6: A match that arrives while a pulse is running neither restarts nor lengthens it. An address held matching therefore gives PULSE_LEN high cycles, one low cycle, then a new pulse.
- R7: With pulse mode at 0, a match holds the output high until the status bit is cleared.
- R8: Writing 1 to offset 0 bit 2 clears the status bit, and in level mode the output falls in the next cycle. Writing 0 to that bit leaves the status unchanged.
- R9: When a clear write and a new match happen in the same cycle, the status stays set and the output stays high.
- R10: In pulse mode, every match also sets the status bit, and it stays set after the pulse ends.
- R11: Offsets 1 and 2 read back the stored address bytes. Offset 0 reads {00000, status, pulse mode, enable} and offset 3 reads 0x00. Each read value appears one clock after the offset is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address bus being watched |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Registered read data |
| bkpt_o | output | 1 | Breakpoint output, active high |

## Verification
The bench presents addresses that differ from the breakpoint in only the low byte, only the high byte, or by a byte swap. A comparator that checks only part of the bus would fire on one of these. It sends a second match in the middle of a pulse and also holds the match address for many cycles. A pulse stage that re-arms on every match would then stretch the pulse or lose the one-cycle gap. It issues a clear write in the same cycle as a match, which a design that gives the clear priority would get wrong by dropping the break. It writes 0 to the status bit, which a design with an ordinary read/write status would treat as a clear. It also checks that disabling the block suppresses both the output and the recorded status.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 2'd0,
    RA_LO   = 2'd1,
    RA_HI   = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int CB_EN    = 0;
  localparam int CB_PULSE = 1;
  localparam int CB_STAT  = 2;
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              status,
  output logic              en,
  output logic              pulse_mode,
  output logic [ADDR_W-1:0] bp_addr,
  output logic              clr_req,
  output logic [DATA_W-1:0] reg_rdata
);
  logic              en_q, pulse_q;
  logic [DATA_W-1:0] byte_q [2];
  logic [DATA_W-1:0] ctrl_view;
  logic              ctrl_wr;

  assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
  assign clr_req = ctrl_wr && reg_wdata[CB_STAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else if (ctrl_wr) begin
      en_q    <= reg_wdata[CB_EN];
      pulse_q <= reg_wdata[CB_PULSE];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        byte_q[g] <= '0;
      else if (reg_we && (reg_addr == REG_AW'(int'(RA_LO) + g)))
        byte_q[g] <= reg_wdata;
    end
  end

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[CB_EN]    = en_q;
    ctrl_view[CB_PULSE] = pulse_q;
    ctrl_view[CB_STAT]  = status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL: reg_rdata <= ctrl_view;
        RA_LO:   reg_rdata <= byte_q[0];
        RA_HI:   reg_rdata <= byte_q[1];
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign en         = en_q;
  assign pulse_mode = pulse_q;
  assign bp_addr    = {byte_q[1], byte_q[0]};

  AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == RA_CTRL) |-> (reg_rdata[DATA_W-1:CB_STAT+1] == '0)); // R11
endmodule

// File: rtl/bkpt_match.sv
module bkpt_match #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int LANES  = ADDR_W / DATA_W
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              en,
  output logic              hit
);
  logic [LANES-1:0] lane_eq;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (cpu_addr[g*DATA_W +: DATA_W] == bp_addr[g*DATA_W +: DATA_W]);
  end

  assign hit = en && (&lane_eq);
endmodule

// File: rtl/bkpt_out.sv
module bkpt_out #(
  parameter int PULSE_LEN = 8,
  localparam int CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1,
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic pulse_mode,
  input  logic clr_req,
  output logic status,
  output logic bkpt_o
);
  logic             status_q, status_d;
  logic             out_q;
  logic [CNT_W-1:0] cnt_q;

  // a match wins over a clear issued in the same cycle
  assign status_d = hit || (status_q && !clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      out_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      status_q <= status_d;
      if (!pulse_mode) begin
        out_q <= status_d;
        cnt_q <= '0;
      end else if (out_q) begin
        if (cnt_q == '0) out_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end else if (hit) begin
        out_q <= 1'b1;
        cnt_q <= LAST;
      end
    end
  end

  assign status = status_q;
  assign bkpt_o = out_q;

  AST_STATUS_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    hit |=> status_q); // R10
  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> ($past(hit) || $past(status_q))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !hit) |=> !status_q); // R8
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr_req) |=> status_q); // R8
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && out_q && cnt_q == '0) |=> (!out_q || !pulse_mode)); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode && out_q && !clr_req) |=> (out_q || pulse_mode)); // R7
endmodule

// File: rtl/bkpt_gen.sv
module bkpt_gen
  import bkpt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PULSE_LEN = 8,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bkpt_o
);
  logic              en, pulse_mode, clr_req, status, hit;
  logic [ADDR_W-1:0] bp_addr;

  bkpt_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .status(status), .en(en), .pulse_mode(pulse_mode),
    .bp_addr(bp_addr), .clr_req(clr_req), .reg_rdata(reg_rdata)
  );

  bkpt_match #(.DATA_W(DATA_W)) i_match (
    .cpu_addr(cpu_addr), .bp_addr(bp_addr), .en(en), .hit(hit)
  );

  bkpt_out #(.PULSE_LEN(PULSE_LEN)) i_out (
    .clk(clk), .rst(rst), .hit(hit), .pulse_mode(pulse_mode),
    .clr_req(clr_req), .status(status), .bkpt_o(bkpt_o)
  );

  AST_DISABLED_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    (!en && !status) |=> !status); // R3
endmodule

// File: tb/test_bkpt_gen.sv
module test_bkpt_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'hAAAA;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic        bkpt_o;

  localparam logic [15:0] IDLE = 16'hAAAA;
  localparam logic [15:0] BP   = 16'h1234;
  localparam logic [1:0]  OFS_CTRL = 2'd0, OFS_LO = 2'd1, OFS_HI = 2'd2, OFS_NONE = 2'd3;

  always #2.5 clk = ~clk;

  bkpt_gen i_bkpt_gen (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .bkpt_o(bkpt_o)
  );

  typedef struct {
    int         at;
    bit         rd;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    total = 0;
  int    fails = 0;
  bit    done = 1'b0;

  task automatic drv(input bit we, input logic [1:0] a, input logic [7:0] d, input logic [15:0] ca);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; cpu_addr = ca;
  endtask

  task automatic exp_bk(input int at, input bit v, input string tag);
    item_t it;
    it.at = at; it.rd = 1'b0; it.exp = {7'd0, v}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_rd(input int at, input logic [7:0] v, input string tag);
    item_t it;
    it.at = at; it.rd = 1'b1; it.exp = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: compares every expectation due in the current cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].at == cyc) begin
          logic [7:0] act;
          act = sbq[i].rd ? reg_rdata : {7'd0, bkpt_o};
          total++;
          if (act !== sbq[i].exp) begin
            fails++;
            $display("FAIL %s: %s cycle %0d got %0h expected %0h", sbq[i].tag,
                     sbq[i].rd ? "rdata" : "bkpt_o", cyc, act, sbq[i].exp);
          end
          sbq.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_bk(cyc + 1, 1'b0, "R1"); exp_rd(cyc + 1, 8'h00, "R1");
    drv(0, OFS_LO, 8'h00, IDLE);   exp_rd(cyc + 1, 8'h00, "R1");
    drv(0, OFS_HI, 8'h00, IDLE);   exp_rd(cyc + 1, 8'h00, "R1");
    // program breakpoint, R11 readback
    drv(1, OFS_LO, BP[7:0], IDLE);
    drv(1, OFS_HI, BP[15:8], IDLE);
    drv(0, OFS_LO, 8'h00, IDLE);   exp_rd(cyc + 1, 8'h34, "R11");
    drv(0, OFS_HI, 8'h00, IDLE);   exp_rd(cyc + 1, 8'h12, "R11");
    drv(1, OFS_NONE, 8'hFF, IDLE);
    drv(0, OFS_NONE, 8'h00, IDLE); exp_rd(cyc + 1, 8'h00, "R11");
    // R3 disabled
    for (int k = 0; k < 3; k++) begin
      drv(0, OFS_CTRL, 8'h00, BP); exp_bk(cyc + 1, 1'b0, "R3");
    end
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_bk(cyc + 1, 1'b0, "R3"); exp_rd(cyc + 1, 8'h00, "R3");
    // enable, level mode; R2 partial matches
    drv(1, OFS_CTRL, 8'h01, IDLE);
    drv(0, OFS_CTRL, 8'h00, 16'h1235); exp_bk(cyc + 1, 1'b0, "R2");
    drv(0, OFS_CTRL, 8'h00, 16'h1334); exp_bk(cyc + 1, 1'b0, "R2");
    drv(0, OFS_CTRL, 8'h00, 16'h3412); exp_bk(cyc + 1, 1'b0, "R2");
    drv(0, OFS_CTRL, 8'h00, IDLE);     exp_bk(cyc + 1, 1'b0, "R2"); exp_rd(cyc + 1, 8'h01, "R2");
    // R4 / R7 level match
    drv(0, OFS_CTRL, 8'h00, BP); exp_bk(cyc + 1, 1'b1, "R4");
    for (int k = 0; k < 5; k++) begin
      drv(0, OFS_CTRL, 8'h00, IDLE); exp_bk(cyc + 1, 1'b1, "R7"); exp_rd(cyc + 1, 8'h05, "R7");
    end
    // R8 write 0 keeps, write 1 clears
    drv(1, OFS_CTRL, 8'h01, IDLE); exp_bk(cyc + 1, 1'b1, "R8");
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_bk(cyc + 1, 1'b1, "R8"); exp_rd(cyc + 1, 8'h05, "R8");
    drv(1, OFS_CTRL, 8'h05, IDLE); exp_bk(cyc + 1, 1'b0, "R8");
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_bk(cyc + 1, 1'b0, "R7"); exp_rd(cyc + 1, 8'h01, "R8");
    // R9 clear and match together
    drv(1, OFS_CTRL, 8'h05, BP);   exp_bk(cyc + 1, 1'b1, "R9");
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_bk(cyc + 1, 1'b1, "R9"); exp_rd(cyc + 1, 8'h05, "R9");
    drv(1, OFS_CTRL, 8'h05, IDLE); exp_bk(cyc + 1, 1'b0, "R8");
    // R5 / R6 pulse mode with a match mid-pulse
    drv(1, OFS_CTRL, 8'h03, IDLE);
    drv(0, OFS_CTRL, 8'h00, BP);
    s = cyc;
    for (int k = 1; k <= 8; k++) exp_bk(s + k, 1'b1, "R5");
    exp_bk(s + 9, 1'b0, "R5");
    exp_bk(s + 10, 1'b0, "R6");
    drv(0, OFS_CTRL, 8'h00, IDLE);
    drv(0, OFS_CTRL, 8'h00, BP);
    repeat (10) drv(0, OFS_CTRL, 8'h00, IDLE);
    // R10 status recorded after pulse
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_rd(cyc + 1, 8'h07, "R10"); exp_bk(cyc + 1, 1'b0, "R10");
    drv(1, OFS_CTRL, 8'h07, IDLE);
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_rd(cyc + 1, 8'h03, "R8");
    // R6 held match repeats with one low cycle
    drv(0, OFS_CTRL, 8'h00, BP);
    s = cyc;
    for (int k = 1; k <= 8; k++) exp_bk(s + k, 1'b1, "R6");
    exp_bk(s + 9, 1'b0, "R6");
    for (int k = 10; k <= 17; k++) exp_bk(s + k, 1'b1, "R6");
    exp_bk(s + 18, 1'b0, "R6");
    repeat (17) drv(0, OFS_CTRL, 8'h00, BP);
    repeat (3) drv(0, OFS_CTRL, 8'h00, IDLE);
    // R3 disabled in pulse mode (also clears status)
    drv(1, OFS_CTRL, 8'h06, IDLE);
    for (int k = 0; k < 3; k++) begin
      drv(0, OFS_CTRL, 8'h00, BP); exp_bk(cyc + 1, 1'b0, "R3");
    end
    drv(0, OFS_CTRL, 8'h00, IDLE); exp_rd(cyc + 1, 8'h02, "R3");
    repeat (4) drv(0, OFS_CTRL, 8'h00, IDLE);
    if (sbq.size() != 0) begin
      total++; fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", sbq.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule